// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block decides, every clock, whether a small 32-bit processor must leave its current instruction stream and where it goes next. It accepts a hard reset request, one non-maskable interrupt (NMI) line and six maskable interrupt lines. It also accepts two return pulses, one that ends an NMI handler and one that ends a maskable handler. When it takes an event, it raises a redirect strobe in the same cycle and presents the new program counter and the new status word (PSW). The core loads both at that clock edge. At the same edge the block captures the saved context registers and the cause register.

The core keeps its PC and PSW in its own registers and feeds them back to this block as `cur_pc` and `cur_psw`. Request lines are edge-triggered. A rising edge sets a pending flag. The flag stays set, and the block retries it on every cycle, until the request is taken. NMI entry is gated by the NMI-active bit of the PSW. Maskable entry is gated by both the NMI-active bit and the interrupt-disable bit. Each maskable source has a fixed vector, and that vector value is also the cause code recorded for the source.

Top module: `irq_entry_ctrl`

## Requirements
- R1: While `hw_reset_req` is high, `redirect` is 1 with `new_pc`=0 and `new_psw`=0x20 in that cycle, whatever else is requested. After the edge, `ecr`=0 and every pending request, including any edge seen in that cycle, is discarded.
- R2: PSW bits are ID (interrupt disable) at bit 5, EP at bit 6 and NP (NMI active) at bit 7. A pending NMI is taken only while NP=0. It redirects to 0x10 with `new_psw` = `cur_psw` with NP and ID set and EP cleared. At the edge, `fepc` gets `cur_pc` and `fepsw` gets `cur_psw`.
- R3: On NMI entry, `ecr[31:16]` is loaded with 0x0010 and `ecr[15:0]` keeps its value.
- R4: An NMI edge that arrives while NP=1 is held and retried each cycle. Any number of edges during that time yield exactly one later entry.
- R5: If a new NMI edge arrives in the very cycle an earlier NMI is taken, it stays pending and is taken once NP clears again.
- R6: A maskable request is not taken while NP=1 or ID=1. It stays pending and is taken once both bits are 0.
- R7: On maskable entry, `new_psw` = `cur_psw` with ID set and EP cleared (NP unchanged). At the edge, `eipc` gets `cur_pc`, `eipsw` gets `cur_psw`, `ecr[15:0]` gets the source code, and `ecr[31:16]` is unchanged.
- R8: Maskable source i (0..5) vectors to 0x80 + 16*i, that is 0x80, 0x90, 0xA0, 0xB0, 0xC0 and 0xD0. Its cause code equals its vector.
- R9: Priority is reset, then return-from-NMI, then return-from-interrupt, then NMI, then maskable sources with the lowest index first. At most one event is taken per cycle. `redirect` is 0 when nothing is taken.
- R10: Requests are latched on rising edges only. A line held high after its request was taken does not cause a second entry.
- R11: `ret_nmi` redirects to `fepc` with PSW `fepsw`, and `ret_int` redirects to `eipc` with PSW `eipsw`. `ret_nmi` wins when both are high. Pending requests are not taken in a return cycle but may be taken in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| hw_reset_req | input | 1 | Processor reset request (level) |
| nmi_req | input | 1 | Non-maskable interrupt request (edge) |
| mi_req | input | 6 | Maskable interrupt requests, bit i = source i (edge) |
| ret_nmi | input | 1 | Return-from-NMI pulse |
| ret_int | input | 1 | Return-from-interrupt pulse |
| cur_pc | input | 32 | Core's current PC |
| cur_psw | input | 32 | Core's current PSW |
| redirect | output | 1 | Core must load new_pc/new_psw at this edge |
| new_pc | output | 32 | Next PC when redirect is 1 |
| new_psw | output | 32 | Next PSW when redirect is 1 |
| fepc | output | 32 | PC saved on NMI entry |
| fepsw | output | 32 | PSW saved on NMI entry |
| eipc | output | 32 | PC saved on maskable entry |
| eipsw | output | 32 | PSW saved on maskable entry |
| ecr | output | 32 | Cause register: [31:16] NMI cause, [15:0] maskable cause |

## Verification
Several properties are checked by assertions on every cycle:
- No entry is taken against the PSW gating bits.
- At most one source is granted per cycle.
- A pending flag never drops unless its request is taken or a reset flushes it.
- NMI entry touches only the upper cause half and captures the current PC.
- A reset request clears the cause register.

Other behaviours need the directed scenarios, because they play out over many cycles against the core model in the bench:
- The collapse of several blocked NMI edges into one later entry.
- The survival of an edge that coincides with an acceptance.
- The order in which simultaneous maskable sources are served after a return.
- The non-retriggering of a held level.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int XLEN       = 32;
  localparam int ECR_HALF   = 16;
  localparam int PSW_ID_BIT = 5;
  localparam int PSW_EP_BIT = 6;
  localparam int PSW_NP_BIT = 7;

  typedef logic [XLEN-1:0] word_t;

  localparam word_t RESET_PSW   = word_t'(32'h20);
  localparam word_t NMI_VECTOR  = word_t'(32'h10);
  localparam word_t MI_VEC_BASE = word_t'(32'h80);
  localparam word_t MI_VEC_STEP = word_t'(32'h10);

  typedef enum logic [2:0] {
    SEL_NONE, SEL_RESET, SEL_RET_NMI, SEL_RET_INT, SEL_NMI, SEL_MI
  } entry_sel_t;

  // vector (and cause code) of maskable source idx
  function automatic word_t mi_vector(input int idx);
    return MI_VEC_BASE + word_t'(idx) * MI_VEC_STEP;
  endfunction

  function automatic word_t nmi_entry_psw(input word_t psw);
    word_t r;
    r = psw;
    r[PSW_NP_BIT] = 1'b1;
    r[PSW_ID_BIT] = 1'b1;
    r[PSW_EP_BIT] = 1'b0;
    return r;
  endfunction

  function automatic word_t mi_entry_psw(input word_t psw);
    word_t r;
    r = psw;
    r[PSW_ID_BIT] = 1'b1;
    r[PSW_EP_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/irq_pend_cell.sv
module irq_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic take,
  input  logic flush,
  output logic avail
);
  logic req_q;
  logic pend_q;
  logic rise;

  assign rise  = req & ~req_q;
  assign avail = pend_q | rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      req_q <= req;
      if (flush)      pend_q <= 1'b0;
      else if (take)  pend_q <= pend_q & rise;
      else            pend_q <= avail;
    end
  end

  // R4: an untaken, unflushed pending flag is kept
  assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !take && !flush |=> pend_q);
  // R10: a rising edge that is not consumed becomes pending
  assert_edge_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise && !take && !flush |=> pend_q);
  // R5: old pending plus new edge at acceptance leaves one pending
  assert_second_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && rise && take && !flush |=> pend_q);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_entry_pkg::*;
#(
  parameter int NUM_MI = 6,
  localparam int IDX_W = (NUM_MI > 1) ? $clog2(NUM_MI) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_reset_req,
  input  logic              ret_nmi,
  input  logic              ret_int,
  input  logic              nmi_avail,
  input  logic [NUM_MI-1:0] mi_avail,
  input  word_t             psw,
  output entry_sel_t        sel,
  output logic              take_nmi,
  output logic [NUM_MI-1:0] take_mi,
  output logic [IDX_W-1:0]  mi_idx
);
  logic [NUM_MI-1:0] gnt;
  logic              found;
  logic              nmi_blocked;
  logic              mi_blocked;

  assign nmi_blocked = psw[PSW_NP_BIT];
  assign mi_blocked  = psw[PSW_NP_BIT] | psw[PSW_ID_BIT];

  always_comb begin
    gnt    = '0;
    found  = 1'b0;
    mi_idx = '0;
    for (int i = 0; i < NUM_MI; i++) begin
      if (mi_avail[i] && !found) begin
        found  = 1'b1;
        gnt[i] = 1'b1;
        mi_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (hw_reset_req)                  sel = SEL_RESET;
    else if (ret_nmi)                  sel = SEL_RET_NMI;
    else if (ret_int)                  sel = SEL_RET_INT;
    else if (nmi_avail && !nmi_blocked) sel = SEL_NMI;
    else if (found && !mi_blocked)     sel = SEL_MI;
    else                               sel = SEL_NONE;
  end

  assign take_nmi = (sel == SEL_NMI);
  assign take_mi  = (sel == SEL_MI) ? gnt : '0;

  // R2: NMI never entered while NP is set
  assert_nmi_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |-> !psw[PSW_NP_BIT]);
  // R6: maskable never entered while NP or ID is set
  assert_mi_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_mi != '0) |-> (!psw[PSW_NP_BIT] && !psw[PSW_ID_BIT]));
  // R9: the granted source has no lower-index competitor
  assert_lowest_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_mi != '0) |-> ((((take_mi - 1'b1) & mi_avail)) == '0));
endmodule

// File: rtl/irq_ctx_regs.sv
module irq_ctx_regs
  import irq_entry_pkg::*;
#(
  parameter int NUM_MI = 6,
  localparam int IDX_W = (NUM_MI > 1) ? $clog2(NUM_MI) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  entry_sel_t       sel,
  input  logic [IDX_W-1:0] mi_idx,
  input  word_t            cur_pc,
  input  word_t            cur_psw,
  output word_t            fepc,
  output word_t            fepsw,
  output word_t            eipc,
  output word_t            eipsw,
  output logic [2*ECR_HALF-1:0] ecr
);
  localparam logic [ECR_HALF-1:0] NMI_CAUSE = NMI_VECTOR[ECR_HALF-1:0];

  word_t mi_code;
  assign mi_code = mi_vector(int'(mi_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fepc  <= '0;
      fepsw <= '0;
      eipc  <= '0;
      eipsw <= '0;
      ecr   <= '0;
    end else begin
      case (sel)
        SEL_RESET: ecr <= '0;
        SEL_NMI: begin
          fepc  <= cur_pc;
          fepsw <= cur_psw;
          ecr[2*ECR_HALF-1:ECR_HALF] <= NMI_CAUSE;
        end
        SEL_MI: begin
          eipc  <= cur_pc;
          eipsw <= cur_psw;
          ecr[ECR_HALF-1:0] <= mi_code[ECR_HALF-1:0];
        end
        default: ;
      endcase
    end
  end

  // R1: reset clears the cause register
  assert_reset_ecr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel == SEL_RESET |=> ecr == '0);
  // R3: NMI entry keeps the maskable half
  assert_nmi_keeps_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel == SEL_NMI |=> ecr[ECR_HALF-1:0] == $past(ecr[ECR_HALF-1:0]));
  // R2: NMI entry saves the PC
  assert_nmi_saves_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel == SEL_NMI |=> fepc == $past(cur_pc));
  // R7: maskable entry keeps the NMI half
  assert_mi_keeps_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sel == SEL_MI |=> ecr[2*ECR_HALF-1:ECR_HALF] == $past(ecr[2*ECR_HALF-1:ECR_HALF]));
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int NUM_MI = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_reset_req,
  input  logic              nmi_req,
  input  logic [NUM_MI-1:0] mi_req,
  input  logic              ret_nmi,
  input  logic              ret_int,
  input  logic [31:0]       cur_pc,
  input  logic [31:0]       cur_psw,
  output logic              redirect,
  output logic [31:0]       new_pc,
  output logic [31:0]       new_psw,
  output logic [31:0]       fepc,
  output logic [31:0]       fepsw,
  output logic [31:0]       eipc,
  output logic [31:0]       eipsw,
  output logic [31:0]       ecr
);
  localparam int IDX_W = (NUM_MI > 1) ? $clog2(NUM_MI) : 1;

  entry_sel_t        sel;
  logic              nmi_avail;
  logic [NUM_MI-1:0] mi_avail;
  logic              take_nmi;
  logic [NUM_MI-1:0] take_mi;
  logic [IDX_W-1:0]  mi_idx;
  logic              flush;

  assign flush = (sel == SEL_RESET);

  irq_pend_cell u_nmi_pend (
    .clk(clk), .rst_n(rst_n), .req(nmi_req), .take(take_nmi),
    .flush(flush), .avail(nmi_avail)
  );

  for (genvar g = 0; g < NUM_MI; g++) begin : g_mi_pend
    irq_pend_cell u_pend (
      .clk(clk), .rst_n(rst_n), .req(mi_req[g]), .take(take_mi[g]),
      .flush(flush), .avail(mi_avail[g])
    );
  end

  irq_arbiter #(.NUM_MI(NUM_MI)) u_arb (
    .clk(clk), .rst_n(rst_n), .hw_reset_req(hw_reset_req),
    .ret_nmi(ret_nmi), .ret_int(ret_int), .nmi_avail(nmi_avail),
    .mi_avail(mi_avail), .psw(cur_psw), .sel(sel),
    .take_nmi(take_nmi), .take_mi(take_mi), .mi_idx(mi_idx)
  );

  irq_ctx_regs #(.NUM_MI(NUM_MI)) u_ctx (
    .clk(clk), .rst_n(rst_n), .sel(sel), .mi_idx(mi_idx),
    .cur_pc(cur_pc), .cur_psw(cur_psw), .fepc(fepc), .fepsw(fepsw),
    .eipc(eipc), .eipsw(eipsw), .ecr(ecr)
  );

  always_comb begin
    redirect = 1'b1;
    case (sel)
      SEL_RESET:   begin new_pc = '0;   new_psw = RESET_PSW; end
      SEL_RET_NMI: begin new_pc = fepc; new_psw = fepsw;     end
      SEL_RET_INT: begin new_pc = eipc; new_psw = eipsw;     end
      SEL_NMI:     begin new_pc = NMI_VECTOR; new_psw = nmi_entry_psw(cur_psw); end
      SEL_MI:      begin new_pc = mi_vector(int'(mi_idx)); new_psw = mi_entry_psw(cur_psw); end
      default:     begin redirect = 1'b0; new_pc = cur_pc; new_psw = cur_psw; end
    endcase
  end

  // R9: one grant per cycle across NMI and maskable sources
  assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_nmi, take_mi}));
  // R1: reset request always redirects to address zero
  assert_reset_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hw_reset_req |-> (redirect && new_pc == 32'h0));
  // R11: a return never coincides with an entry
  assert_return_defers_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_nmi || ret_int) |-> (!take_nmi && take_mi == '0));
endmodule

// File: tb/test_irq_entry_ctrl.sv
`timescale 1ns/1ps
module test_irq_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_reset_req = 1'b0;
  logic        nmi_req = 1'b0;
  logic [5:0]  mi_req = '0;
  logic        ret_nmi = 1'b0;
  logic        ret_int = 1'b0;
  logic [31:0] core_pc, core_psw;
  logic        set_en = 1'b0;
  logic [31:0] set_pc = '0, set_psw = '0;
  logic        redirect;
  logic [31:0] new_pc, new_psw, fepc, fepsw, eipc, eipsw, ecr;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_entry_ctrl i_irq_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .hw_reset_req(hw_reset_req), .nmi_req(nmi_req),
    .mi_req(mi_req), .ret_nmi(ret_nmi), .ret_int(ret_int), .cur_pc(core_pc),
    .cur_psw(core_psw), .redirect(redirect), .new_pc(new_pc), .new_psw(new_psw),
    .fepc(fepc), .fepsw(fepsw), .eipc(eipc), .eipsw(eipsw), .ecr(ecr)
  );

  // core model
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_pc  <= '0;
      core_psw <= '0;
    end else if (redirect) begin
      core_pc  <= new_pc;
      core_psw <= new_psw;
    end else if (set_en) begin
      core_pc  <= set_pc;
      core_psw <= set_psw;
    end
  end

  function automatic logic [31:0] vec_of(input int src);
    return 32'((8 + src) << 4);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_core(input logic [31:0] pc, input logic [31:0] psw);
    set_en = 1'b1; set_pc = pc; set_psw = psw;
    step();
    set_en = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R9", "redirect after reset", 32'(redirect), 0);
    chk("R1", "ecr after reset", ecr, 0);
    chk("R2", "fepc after reset", fepc, 0);
  endtask

  task automatic t_nmi_entry();
    set_core(32'h1234, 32'h43);
    nmi_req = 1'b1; #1;
    chk("R2", "nmi redirect", 32'(redirect), 1);
    chk("R2", "nmi vector", new_pc, 32'h10);
    chk("R2", "nmi psw (EP cleared)", new_psw, 32'ha3);
    step(); nmi_req = 1'b0;
    chk("R2", "fepc", fepc, 32'h1234);
    chk("R2", "fepsw", fepsw, 32'h43);
    chk("R3", "ecr after nmi", ecr, 32'h0010_0000);
  endtask

  task automatic t_nmi_pending();
    // NP is set now: two edges while blocked
    nmi_req = 1'b1; #1;
    chk("R4", "blocked nmi edge 1", 32'(redirect), 0);
    step(); nmi_req = 1'b0; step();
    nmi_req = 1'b1; #1;
    chk("R4", "blocked nmi edge 2", 32'(redirect), 0);
    step(); nmi_req = 1'b0;
    ret_nmi = 1'b1; #1;
    chk("R11", "ret_nmi redirect", 32'(redirect), 1);
    chk("R11", "ret_nmi pc", new_pc, 32'h1234);
    chk("R11", "ret_nmi psw", new_psw, 32'h43);
    step(); ret_nmi = 1'b0;
    nmi_req = 1'b1; #1;  // new edge in the acceptance cycle
    chk("R4", "held nmi taken", new_pc, 32'h10);
    chk("R4", "held nmi redirect", 32'(redirect), 1);
    step(); nmi_req = 1'b0; #1;
    chk("R4", "no entry while NP", 32'(redirect), 0);
    step();
    ret_nmi = 1'b1; step(); ret_nmi = 1'b0; #1;
    chk("R5", "coinciding edge kept", 32'(redirect), 1);
    chk("R5", "coinciding edge vector", new_pc, 32'h10);
    step();
    ret_nmi = 1'b1; step(); ret_nmi = 1'b0; #1;
    chk("R4", "only one extra nmi", 32'(redirect), 0);
    step();
  endtask

  task automatic t_mask_priority();
    set_core(32'h2000, 32'h0);
    mi_req = 6'b010100; #1;
    chk("R9", "lowest index wins", new_pc, 32'ha0);
    chk("R7", "mi psw", new_psw, 32'h20);
    step(); mi_req = '0;
    chk("R7", "eipc", eipc, 32'h2000);
    chk("R7", "eipsw", eipsw, 32'h0);
    chk("R7", "ecr after mi2", ecr, 32'h0010_0000 | vec_of(2));
    #1 chk("R6", "ID blocks source 4", 32'(redirect), 0);
    step();
    ret_int = 1'b1; #1;
    chk("R11", "ret_int pc", new_pc, 32'h2000);
    chk("R11", "ret_int psw", new_psw, 32'h0);
    step(); ret_int = 1'b0; #1;
    chk("R8", "source 4 vector", new_pc, vec_of(4));
    step();
    chk("R8", "source 4 cause", ecr, 32'h0010_0000 | vec_of(4));
  endtask

  task automatic t_mask_gating();
    set_core(32'h3000, 32'h20);
    mi_req[0] = 1'b1; #1;
    chk("R6", "ID blocks source 0", 32'(redirect), 0);
    step(); mi_req[0] = 1'b0;
    set_core(32'h3000, 32'h0); #1;
    chk("R8", "source 0 vector", new_pc, vec_of(0));
    step();
    chk("R8", "source 0 cause", ecr, 32'h0010_0000 | vec_of(0));
    set_core(32'h3100, 32'h80);
    mi_req[5] = 1'b1; #1;
    chk("R6", "NP blocks source 5", 32'(redirect), 0);
    step(); mi_req[5] = 1'b0;
    set_core(32'h3100, 32'h41); #1;
    chk("R8", "source 5 vector", new_pc, vec_of(5));
    chk("R7", "EP cleared ID set", new_psw, 32'h21);
    step();
  endtask

  task automatic t_level_hold();
    set_core(32'h3200, 32'h0);
    mi_req[1] = 1'b1; #1;
    chk("R8", "source 1 vector", new_pc, vec_of(1));
    step();
    ret_int = 1'b1; step(); ret_int = 1'b0; #1;
    chk("R10", "held level no retrigger", 32'(redirect), 0);
    step(); mi_req[1] = 1'b0;
  endtask

  task automatic t_nmi_over_mask();
    set_core(32'h4000, 32'h0);
    nmi_req = 1'b1; mi_req[3] = 1'b1; #1;
    chk("R9", "nmi beats maskable", new_pc, 32'h10);
    step(); nmi_req = 1'b0; mi_req[3] = 1'b0;
    ret_nmi = 1'b1; ret_int = 1'b1; #1;
    chk("R11", "ret_nmi wins over ret_int", new_pc, 32'h4000);
    step(); ret_nmi = 1'b0; ret_int = 1'b0; #1;
    chk("R9", "maskable after nmi return", new_pc, vec_of(3));
    step();
  endtask

  task automatic t_hw_reset();
    set_core(32'h5000, 32'h20);
    mi_req[0] = 1'b1; step(); mi_req[0] = 1'b0;
    hw_reset_req = 1'b1; nmi_req = 1'b1; #1;
    chk("R1", "reset pc", new_pc, 32'h0);
    chk("R1", "reset psw", new_psw, 32'h20);
    step(); hw_reset_req = 1'b0; nmi_req = 1'b0;
    chk("R1", "reset ecr", ecr, 32'h0);
    set_core(32'h5000, 32'h0); #1;
    chk("R1", "pending flushed", 32'(redirect), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset_state();
    t_nmi_entry();
    t_nmi_pending();
    t_mask_priority();
    t_mask_gating();
    t_level_hold();
    t_nmi_over_mask();
    t_hw_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule